// File: doc/BRIEF.md
# 16x16 Multiply-Accumulate Unit with 40-bit Accumulator

This block is a DSP helper attached to a 32-bit processor pipeline. Each operation multiplies two 16-bit halves. Each half is taken from a 32-bit operand, and each operand comes either from a general-register value on an input port or from the unit's own bank of four 32-bit data registers. The product can do one of three things to a 40-bit accumulator: replace it, be added to it, or be subtracted from it. The accumulator is read out as a 32-bit low word and an 8-bit high word.

The unit also fills its data registers from memory. A load operation writes a 32-bit memory word, supplied on the load-data input, into one data register. In the same cycle it returns the address advanced or retreated by one word. Two fused operations combine a signed multiply-accumulate with such a load, so a filter inner loop can fetch its next coefficient pair while consuming the current one. The memory system itself lies outside the block.

Top module: `mac40_unit`

## Requirements
- R1: After synchronous reset the accumulator, the returned address and all four data registers read zero.
- R2: `qq[1]` picks the upper 16 bits of the first operand when 1 and the lower 16 bits when 0. `qq[0]` does the same for the second operand.
- R3: Op code 1 (unsigned multiply) overwrites the accumulator with the zero-extended 32-bit product. Op code 2 (signed multiply) overwrites it with the sign-extended product.
- R4: Op code 3 adds the signed product to the accumulator, wrapping modulo 2^40.
- R5: Op code 4 subtracts the signed product from the accumulator, wrapping modulo 2^40 with no saturation.
- R6: The first operand is `gen_a` when `src_a`=0, or data register 0/1 (picked by `sel_a`) when `src_a`=1. The second operand is `gen_b` when `src_b`=0, or data register 2/3 (picked by `sel_b`) when `src_b`=1.
- R7: Op code 5 writes `ld_data` into data register `ld_dst` and returns `addr_in`+4. Op code 6 does the same and returns `addr_in`-4. Both wrap modulo 2^32 and leave the accumulator unchanged.
- R8: Op codes 7 and 8 perform the signed accumulate of R4 and, in the same cycle, the load of R7 (increment and decrement respectively). The multiply sees the data register's value from before the load.
- R9: With `op_valid` low, or with op code 0 or 9 to 15, the accumulator, the returned address and the data registers keep their values.
- R10: Results are registered. `acc_lo` and `acc_hi` show accumulator bits 31:0 and 39:32 one clock edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| qq | input | 2 | Half select for the first (bit 1) and second (bit 0) operands |
| src_a | input | 1 | First operand source: 0 general, 1 data register |
| src_b | input | 1 | Second operand source: 0 general, 1 data register |
| sel_a | input | 1 | Data register 0 or 1 for the first operand |
| sel_b | input | 1 | Data register 2 or 3 for the second operand |
| gen_a | input | 32 | General-register value, first operand |
| gen_b | input | 32 | General-register value, second operand |
| ld_dst | input | 2 | Data register written by a load |
| ld_data | input | 32 | Memory word for a load |
| addr_in | input | 32 | Load address |
| addr_out | output | 32 | Updated address, registered |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 8 | Accumulator bits 39:32 |

## Verification
A corrupted data register is invisible until an operation reads it as an operand. From then on, every product taken from that register is wrong, and the error appears on `acc_lo`/`acc_hi` one edge later. Because the accumulator integrates, a single wrong sign extension or a single wrong half selection stays in `acc_hi` for every later accumulate. The sweep therefore compares the whole 40-bit value after every operation, so the first bad operation is the one reported. A wrong fused-load ordering shows up on the fused operation itself, and the new register value shows up on the next multiply that reads it.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_UMUL     = 4'd1,
    OP_SMUL     = 4'd2,
    OP_MACC     = 4'd3,
    OP_MSUB     = 4'd4,
    OP_LD_UP    = 4'd5,
    OP_LD_DN    = 4'd6,
    OP_MACC_UP  = 4'd7,
    OP_MACC_DN  = 4'd8
  } mac_op_e;

  typedef enum logic [1:0] {
    ACC_SET = 2'd0,
    ACC_ADD = 2'd1,
    ACC_SUB = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/mac40_dreg_bank.sv
module mac40_dreg_bank #(
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(NREG)-1:0]   waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [$clog2(NREG)-2:0]   sel_lo,
  input  logic [$clog2(NREG)-2:0]   sel_hi,
  output logic [DW-1:0]             rd_lo,
  output logic [DW-1:0]             rd_hi
);
  localparam int IW   = $clog2(NREG);
  localparam int HALF = NREG / 2;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // first operand draws from the lower half of the bank, second from the upper half
  assign rd_lo = regs[{1'b0, sel_lo}];
  assign rd_hi = regs[IW'(HALF) + IW'(sel_hi)];

  for (genvar g = 0; g < NREG; g++) begin : g_keep
    AST_DREG_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(we && waddr == IW'(g)) |=> regs[g] == $past(regs[g])); // R9
    AST_DREG_WRITE: assert property (@(posedge clk) disable iff (rst)
      (we && waddr == IW'(g)) |=> regs[g] == $past(wdata)); // R7
  end
endmodule

// File: rtl/mac40_mul.sv
module mac40_mul #(
  parameter int DW   = 32,
  parameter int HW   = 16,
  parameter int ACCW = 40
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic            hi_a,
  input  logic            hi_b,
  input  logic            signed_en,
  output logic [ACCW-1:0] prod
);
  localparam int EW = HW + 1;
  localparam int PW = 2 * EW;

  logic [HW-1:0]        ha, hb;
  logic signed [EW-1:0] ea, eb;
  logic signed [PW-1:0] p;

  assign ha = hi_a ? opa[DW-1 -: HW] : opa[HW-1:0];
  assign hb = hi_b ? opb[DW-1 -: HW] : opb[HW-1:0];
  // one extra bit carries either the sign or a zero, so one signed multiplier serves both forms
  assign ea = $signed({signed_en & ha[HW-1], ha});
  assign eb = $signed({signed_en & hb[HW-1], hb});
  assign p  = ea * eb;
  assign prod = {{(ACCW-PW){p[PW-1]}}, p};
endmodule

// File: rtl/mac40_acc.sv
module mac40_acc
  import mac40_pkg::*;
#(
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  acc_mode_e       mode,
  input  logic [ACCW-1:0] prod,
  output logic [ACCW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      unique case (mode)
        ACC_ADD: acc <= acc + prod;
        ACC_SUB: acc <= acc - prod;
        default: acc <= prod;
      endcase
    end
  end

  AST_ACC_KEEP: assert property (@(posedge clk) disable iff (rst)
    !en |=> acc == $past(acc)); // R9
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DW    = 32,
  parameter int HW    = 16,
  parameter int ACCW  = 40,
  parameter int NREG  = 4,
  parameter int ADDRW = 32,
  parameter int STEP  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [3:0]              op_code,
  input  logic [1:0]              qq,
  input  logic                    src_a,
  input  logic                    src_b,
  input  logic [$clog2(NREG)-2:0] sel_a,
  input  logic [$clog2(NREG)-2:0] sel_b,
  input  logic [DW-1:0]           gen_a,
  input  logic [DW-1:0]           gen_b,
  input  logic [$clog2(NREG)-1:0] ld_dst,
  input  logic [DW-1:0]           ld_data,
  input  logic [ADDRW-1:0]        addr_in,
  output logic [ADDRW-1:0]        addr_out,
  output logic [DW-1:0]           acc_lo,
  output logic [ACCW-DW-1:0]      acc_hi
);
  mac_op_e   op;
  acc_mode_e mode;
  logic      do_mul, sgn, do_ld, ld_down;
  logic [DW-1:0]   rd_a, rd_b, opa, opb;
  logic [ACCW-1:0] prod, acc;
  logic [ADDRW-1:0] addr_q;

  assign op = mac_op_e'(op_code);

  always_comb begin
    do_mul  = 1'b0;
    sgn     = 1'b1;
    do_ld   = 1'b0;
    ld_down = 1'b0;
    mode    = ACC_SET;
    case (op)
      OP_UMUL:    begin do_mul = 1'b1; sgn = 1'b0; end
      OP_SMUL:    do_mul = 1'b1;
      OP_MACC:    begin do_mul = 1'b1; mode = ACC_ADD; end
      OP_MSUB:    begin do_mul = 1'b1; mode = ACC_SUB; end
      OP_LD_UP:   do_ld = 1'b1;
      OP_LD_DN:   begin do_ld = 1'b1; ld_down = 1'b1; end
      OP_MACC_UP: begin do_mul = 1'b1; mode = ACC_ADD; do_ld = 1'b1; end
      OP_MACC_DN: begin do_mul = 1'b1; mode = ACC_ADD; do_ld = 1'b1; ld_down = 1'b1; end
      default:    ;
    endcase
  end

  mac40_dreg_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .we(op_valid & do_ld), .waddr(ld_dst), .wdata(ld_data),
    .sel_lo(sel_a), .sel_hi(sel_b), .rd_lo(rd_a), .rd_hi(rd_b)
  );

  assign opa = src_a ? rd_a : gen_a;
  assign opb = src_b ? rd_b : gen_b;

  mac40_mul #(.DW(DW), .HW(HW), .ACCW(ACCW)) u_mul (
    .opa(opa), .opb(opb), .hi_a(qq[1]), .hi_b(qq[0]), .signed_en(sgn), .prod(prod)
  );

  mac40_acc #(.ACCW(ACCW)) u_acc (
    .clk(clk), .rst(rst), .en(op_valid & do_mul), .mode(mode), .prod(prod), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (op_valid && do_ld)
      addr_q <= ld_down ? addr_in - ADDRW'(STEP) : addr_in + ADDRW'(STEP);
  end

  assign addr_out = addr_q;
  assign acc_lo   = acc[DW-1:0];
  assign acc_hi   = acc[ACCW-1:DW];

  AST_UMUL_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd1) |=> acc_hi == '0); // R3
  AST_SMUL_SEXT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd2) |=> (acc_hi == '0 && !acc_lo[DW-1]) || (acc_hi == '1 && acc_lo[DW-1])); // R3
  AST_ADDR_UP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd5 || op_code == 4'd7)) |=> addr_out == $past(addr_in) + ADDRW'(STEP)); // R7
  AST_ADDR_DN: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd6 || op_code == 4'd8)) |=> addr_out == $past(addr_in) - ADDRW'(STEP)); // R7
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_code >= 4'd5 && op_code <= 4'd8) |=> $stable(addr_out)); // R9
endmodule

// File: tb/tb_mac40_unit.sv
module tb_mac40_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  qq;
  logic        src_a, src_b, sel_a, sel_b;
  logic [31:0] gen_a, gen_b, ld_data, addr_in;
  logic [1:0]  ld_dst;
  logic [31:0] addr_out, acc_lo;
  logic [7:0]  acc_hi;

  int nerr = 0;
  int nchk = 0;
  logic [39:0] m_acc;
  logic [31:0] m_dr [4];
  logic [31:0] m_addr;

  always #5 clk = ~clk;

  mac40_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .qq(qq),
    .src_a(src_a), .src_b(src_b), .sel_a(sel_a), .sel_b(sel_b),
    .gen_a(gen_a), .gen_b(gen_b), .ld_dst(ld_dst), .ld_data(ld_data),
    .addr_in(addr_in), .addr_out(addr_out), .acc_lo(acc_lo), .acc_hi(acc_hi)
  );

  function automatic logic [15:0] val(input int k);
    case (k)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF; 3: return 16'h8000;
      4: return 16'hFFFF; 5: return 16'h1234; 6: return 16'hA5C3; default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic [39:0] mprod(input logic uns, input logic [31:0] a, b, input logic [1:0] q);
    logic [15:0] ha, hb;
    logic signed [39:0] sa, sb;
    ha = q[1] ? a[31:16] : a[15:0];
    hb = q[0] ? b[31:16] : b[15:0];
    if (uns) return {24'h0, ha} * {24'h0, hb};
    sa = {{24{ha[15]}}, ha};
    sb = {{24{hb[15]}}, hb};
    return sa * sb;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({acc_hi, acc_lo} == m_acc, tag, {acc_hi, acc_lo}, m_acc);
    chk(addr_out == m_addr, tag, {8'h0, addr_out}, {8'h0, m_addr});
  endtask

  // present one operation at a negedge; results are checked at the next negedge
  task automatic run(input logic v, input logic [3:0] oc);
    op_valid = v;
    op_code  = oc;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [31:0] opA();
    return src_a ? m_dr[{1'b0, sel_a}] : gen_a;
  endfunction
  function automatic logic [31:0] opB();
    return src_b ? m_dr[{1'b1, sel_b}] : gen_b;
  endfunction

  task automatic load(input logic [1:0] d, input logic [31:0] data, input logic [31:0] a, input bit down);
    ld_dst = d; ld_data = data; addr_in = a;
    run(1'b1, down ? 4'd6 : 4'd5);
    m_dr[d] = data;
    m_addr  = down ? a - 32'd4 : a + 32'd4;
    chk_state("R7 load address/accumulator");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 4'd0; qq = 2'd0;
    src_a = 1'b0; src_b = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
    gen_a = '0; gen_b = '0; ld_dst = '0; ld_data = '0; addr_in = '0;
    m_acc = '0; m_addr = '0;
    for (int r = 0; r < 4; r++) m_dr[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_state("R1 reset");
    // R1: data registers read zero through a multiply
    src_a = 1'b1; src_b = 1'b1; gen_a = 32'hFFFF_FFFF; qq = 2'b11;
    run(1'b1, 4'd2);
    chk_state("R1 data registers zero after reset");

    // R7 boundary: decrement below zero wraps, increment past top wraps
    load(2'd0, 32'h1111_2222, 32'h0, 1'b1);
    load(2'd1, 32'h3333_4444, 32'hFFFF_FFFC, 1'b0);

    // sweep: R2 R3 R4 R5 R6 R10 over value pairs, op, sources, halves
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] va, vb;
        va = val(i); vb = val(j);
        load(2'd0, {va, vb}, 32'h100 + 32'(i), 1'b0);
        load(2'd1, {vb, va}, 32'h200 + 32'(j), 1'b1);
        load(2'd2, {~va, vb}, 32'h300, 1'b0);
        load(2'd3, {vb, ~vb}, 32'h400, 1'b1);
        gen_a = {vb, va}; gen_b = {va, ~vb};
        for (int oc = 1; oc <= 4; oc++) begin
          for (int s = 0; s < 4; s++) begin
            for (int q = 0; q < 4; q++) begin
              logic [39:0] p;
              src_a = s[1]; src_b = s[0]; qq = q[1:0];
              sel_a = 1'((q + i) % 2); sel_b = 1'((q + j) % 2);
              p = mprod(oc == 1, opA(), opB(), qq);
              case (oc)
                1, 2:    m_acc = p;
                3:       m_acc = m_acc + p;
                default: m_acc = m_acc - p;
              endcase
              run(1'b1, 4'(oc));
              chk_state($sformatf("R2 R3 R4 R5 R6 R10 op=%0d src=%0d qq=%0d", oc, s, q));
            end
          end
        end
      end
    end

    // R5 boundary: subtracting from zero wraps to all ones
    gen_a = 32'h0000_0001; gen_b = 32'h0000_0001; src_a = 0; src_b = 0; qq = 2'b00;
    run(1'b1, 4'd1); m_acc = 40'h1; chk_state("R3 unsigned 1*1");
    run(1'b1, 4'd4); run(1'b1, 4'd4);
    m_acc = 40'hFF_FFFF_FFFF; chk_state("R5 wrap below zero");
    // R4 boundary: adding back wraps past the top
    run(1'b1, 4'd3); run(1'b1, 4'd3);
    m_acc = 40'h1; chk_state("R4 wrap past top");
    // R3: unsigned vs signed of 0xFFFF*0xFFFF
    gen_a = 32'h0000_FFFF; gen_b = 32'h0000_FFFF;
    run(1'b1, 4'd1); m_acc = 40'h00_FFFE_0001; chk_state("R3 unsigned max");
    run(1'b1, 4'd2); m_acc = 40'h1; chk_state("R3 signed -1*-1");

    // R8: fused accumulate reads the old register value, load takes effect afterwards
    load(2'd0, 32'h0000_0003, 32'h40, 1'b0);
    src_a = 1; sel_a = 0; src_b = 0; gen_b = 32'h0000_0005; qq = 2'b00;
    ld_dst = 2'd0; ld_data = 32'h0000_0007; addr_in = 32'h80;
    run(1'b1, 4'd7);
    m_acc = m_acc + 40'd15; m_dr[0] = 32'h7; m_addr = 32'h84;
    chk_state("R8 fused increment uses old value");
    ld_data = 32'h0000_0009; addr_in = 32'h0;
    run(1'b1, 4'd8);
    m_acc = m_acc + 40'd35; m_dr[0] = 32'h9; m_addr = 32'hFFFF_FFFC;
    chk_state("R8 fused decrement sees prior load");
    run(1'b1, 4'd2);
    m_acc = 40'd45; chk_state("R8 second load visible");

    // R9: strobe low or reserved codes change nothing
    ld_dst = 2'd0; ld_data = 32'hDEAD_BEEF; addr_in = 32'h1234_0000;
    run(1'b0, 4'd7);
    chk_state("R9 strobe low");
    for (int oc = 9; oc < 16; oc++) begin
      run(1'b1, 4'(oc));
      chk_state($sformatf("R9 reserved op %0d", oc));
    end
    run(1'b1, 4'd0);
    chk_state("R9 op 0");
    run(1'b1, 4'd2);
    m_acc = 40'd45; chk_state("R9 data register untouched");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule